// File: doc/BRIEF.md
# Zero-Crossing Synchronized Source Selector

This block drives a registered signed output from one of two signed data inputs, `a` and `b`. A signed control word `w` sets which source is wanted. While `w` is below a fixed threshold the output follows `a`. When `w` is at or above the threshold, the output does not move to `b` at once. It waits until a separate signed reference input `c` changes sign, so the change of source lines up with a zero crossing of the reference.

After the first crossing with `w` high, the block keeps passing `b` for as long as `w` stays at or above the threshold. Later sign changes of `c` have no effect. When `w` drops below the threshold, the output goes back to `a` on the next clock without waiting for a crossing. A later return of `w` above the threshold then needs a new crossing. A crossing means that the sign bit of `c` differs from the sign bit sampled one clock earlier, so a value of zero counts as non-negative. The output register, the held sign sample and the switched state are all cleared by a synchronous active-high reset.

Top module: `zc_sync_selector`

## Requirements
- R1: While `rst` is high at a rising clock edge, `o` becomes 0 after that edge.
- R2: When `w` is below the threshold at an edge, `o` equals the `a` sampled at that edge after the edge. Any change of `c` has no effect in this case.
- R3: `w` is compared as a signed number against 2867 (16'h0B33). 2866 and negative values such as -2000 are below it. 2867 counts as at or above.
- R4: When `w` is at or above the threshold and no crossing has been seen since `w` rose, `o` keeps taking the value of `a`, including when `a` changes.
- R5: A change of `c` from non-negative to negative (bit 15 going 0 to 1) while `w` is at or above the threshold makes `o` equal to the `b` sampled at that same edge.
- R6: A change of `c` from negative to non-negative, including to exactly zero (bit 15 going 1 to 0), also counts as a crossing and switches `o` to `b`.
- R7: Once switched, `o` follows the live `b` every cycle while `w` stays at or above the threshold, and further sign changes of `c` do not move it back to `a`.
- R8: When `w` falls below the threshold, `o` shows `a` after the next edge. If `w` then returns above the threshold, `o` stays on `a` until a new crossing.
- R9: At the first edge after reset is released, the sign of `c` is only sampled. It is not compared, so a sign that differs from the one present during reset does not cause a switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| w | input | 16 | Signed control word compared with the threshold |
| a | input | 16 | Signed source used while not switched |
| b | input | 16 | Signed source used after a crossing |
| c | input | 16 | Signed reference whose sign change gates the switch |
| o | output | 16 | Registered signed selected output |

## Verification
The stimulus applies `w` values just below the threshold, exactly at it and far above it, plus a negative value. Together these show a signed comparison with the correct boundary, as opposed to an unsigned one or one that is off by one. With `w` high, `c` is held on one side of zero while `a` changes, then driven through falling and rising sign changes, one of them ending at exactly zero. This separates a switch that waits for a real crossing from one that fires as soon as `w` rises. Dropping `w` and raising it again with `c` unchanged shows that the switched state clears. A reset with `c` of one sign followed by a release with the opposite sign shows that the first sample after reset is never compared.

// File: rtl/zc_sel_pkg.sv
package zc_sel_pkg;

    // Which data input the output register is loading from.
    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_e;

    // State of the sign tracker: last sampled sign and whether that sample is valid.
    typedef struct packed {
        logic sign;
        logic primed;
    } sign_state_t;

endpackage

// File: rtl/zc_thresh_cmp.sv
module zc_thresh_cmp #(
    parameter int                        DATA_W = 16,
    parameter logic signed [DATA_W-1:0]  THRESH = 16'sh0B33
) (
    input  logic signed [DATA_W-1:0] w,
    output logic                     at_or_above
);

    // Signed compare: negative control words are always below a positive threshold.
    always_comb begin
        at_or_above = (w >= THRESH);
    end

endmodule

// File: rtl/zc_sign_tracker.sv
module zc_sign_tracker
    import zc_sel_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] c,
    output logic                     crossing
);

    localparam int SIGN_IDX = DATA_W - 1;

    sign_state_t st_d, st_q;
    logic        cur_sign;

    always_comb begin
        cur_sign    = c[SIGN_IDX];
        st_d.sign   = cur_sign;
        st_d.primed = 1'b1;
        // Only compare against a sample that was taken after reset.
        crossing    = st_q.primed && (cur_sign != st_q.sign);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/zc_select_core.sv
module zc_select_core
    import zc_sel_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     at_or_above,
    input  logic                     crossing,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    output logic signed [DATA_W-1:0] o
);

    typedef struct packed {
        src_e                     src;
        logic signed [DATA_W-1:0] data;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!at_or_above) begin
            // Falling below the threshold returns to a at once.
            st_d.src  = SRC_A;
            st_d.data = a;
        end else if (st_q.src == SRC_B || crossing) begin
            st_d.src  = SRC_B;
            st_d.data = b;
        end else begin
            st_d.src  = SRC_A;
            st_d.data = a;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{src: SRC_A, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign o = st_q.data;

endmodule

// File: rtl/zc_sync_selector.sv
module zc_sync_selector #(
    parameter int                        DATA_W     = 16,
    parameter logic signed [DATA_W-1:0]  THRESH_VAL = 16'sh0B33
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] w,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    input  logic signed [DATA_W-1:0] c,
    output logic signed [DATA_W-1:0] o
);

    logic at_or_above;
    logic crossing;

    zc_thresh_cmp #(
        .DATA_W (DATA_W),
        .THRESH (THRESH_VAL)
    ) i_cmp (
        .w           (w),
        .at_or_above (at_or_above)
    );

    zc_sign_tracker #(
        .DATA_W (DATA_W)
    ) i_sign (
        .clk      (clk),
        .rst      (rst),
        .c        (c),
        .crossing (crossing)
    );

    zc_select_core #(
        .DATA_W (DATA_W)
    ) i_core (
        .clk         (clk),
        .rst         (rst),
        .at_or_above (at_or_above),
        .crossing    (crossing),
        .a           (a),
        .b           (b),
        .o           (o)
    );

endmodule

// File: rtl/zc_sync_selector_chk.sv
module zc_sync_selector_chk #(
    parameter int                        DATA_W     = 16,
    parameter logic signed [DATA_W-1:0]  THRESH_VAL = 16'sh0B33
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] w,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    input  logic signed [DATA_W-1:0] c,
    input  logic signed [DATA_W-1:0] o
);

    logic high;
    logic seen_q;
    logic prev_sign_q;
    logic on_b_q;
    logic edge_seen;

    assign high      = (w >= THRESH_VAL);
    assign edge_seen = seen_q && (c[DATA_W-1] != prev_sign_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q      <= 1'b0;
            prev_sign_q <= 1'b0;
            on_b_q      <= 1'b0;
        end else begin
            seen_q      <= 1'b1;
            prev_sign_q <= c[DATA_W-1];
            on_b_q      <= high && (on_b_q || edge_seen);
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> (o == '0));

    // R2
    below_follows_a_chk: assert property (@(posedge clk) disable iff (rst)
        !high |=> (o == $past(a)));

    // R5
    crossing_takes_b_chk: assert property (@(posedge clk) disable iff (rst)
        (high && edge_seen) |=> (o == $past(b)));

    // R7
    sticky_b_chk: assert property (@(posedge clk) disable iff (rst)
        (high && on_b_q) |=> (o == $past(b)));

    // R4
    hold_a_chk: assert property (@(posedge clk) disable iff (rst)
        (high && !on_b_q && !edge_seen) |=> (o == $past(a)));

endmodule

bind zc_sync_selector zc_sync_selector_chk #(
    .DATA_W     (DATA_W),
    .THRESH_VAL (THRESH_VAL)
) i_zc_sync_selector_chk (
    .clk (clk),
    .rst (rst),
    .w   (w),
    .a   (a),
    .b   (b),
    .c   (c),
    .o   (o)
);

// File: tb/test_zc_sync_selector.sv
`timescale 1ns/1ps
module test_zc_sync_selector;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [15:0] w = '0;
    logic signed [15:0] a = '0;
    logic signed [15:0] b = '0;
    logic signed [15:0] c = '0;
    logic signed [15:0] o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;   // 50 MHz

    zc_sync_selector i_zc_sync_selector (
        .clk (clk), .rst (rst), .w (w), .a (a), .b (b), .c (c), .o (o)
    );

    // Drive on the falling edge, let one rising edge pass, then sample.
    task automatic step(input logic r, input int wv, input int av, input int bv,
                        input int cv, input int expv, input string req);
        @(negedge clk);
        rst = r; w = 16'(wv); a = 16'(av); b = 16'(bv); c = 16'(cv);
        @(posedge clk);
        #2;
        total++;
        if (o !== 16'(expv)) begin
            bad++;
            $display("FAIL %s: o=%0d expected=%0d", req, o, 16'sh0 + $signed(16'(expv)));
        end
    endtask

    task automatic t_reset();
        step(1, 5000, 9, 8, -3, 0, "R1");
        step(1, 100, 9, 8, 3, 0, "R1");
    endtask

    task automatic t_below();
        step(0, 100, 11, 12, 5, 11, "R2");
        step(0, -2000, 22, 23, -5, 22, "R3");
        step(0, 2866, 33, 34, 6, 33, "R3");
    endtask

    task automatic t_hold();
        step(0, 2867, 40, 41, 7, 40, "R4");
        step(0, 2867, -40, 41, 40, -40, "R4");
        step(0, 20000, 50, 51, 40, 50, "R4");
    endtask

    task automatic t_cross();
        step(0, 2867, 40, 41, -1, 41, "R5");
        step(0, 3000, 42, 43, 5, 43, "R7");
        step(0, 32767, 44, 45, -50, 45, "R7");
    endtask

    task automatic t_drop();
        step(0, 2000, 1, 2, -50, 1, "R8");
        step(0, 4000, 3, 4, -60, 3, "R8");
        step(0, 4000, 5, 6, -1, 5, "R8");
        step(0, 4000, 7, 8, 0, 8, "R6");
        step(0, 4000, 9, 10, 0, 10, "R7");
    endtask

    task automatic t_first_sample();
        step(1, 4000, 1, 2, 5, 0, "R1");
        step(0, 4000, 60, 61, -5, 60, "R9");
        step(0, 4000, 62, 63, -5, 62, "R9");
        step(0, 4000, 64, 65, 1, 65, "R6");
    endtask

    initial begin
        t_reset();
        t_below();
        t_hold();
        t_cross();
        t_drop();
        t_first_sample();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule